// File: doc/BRIEF.md
# Virtual Address Translation Front End

This block takes one translation request at a time: a 64-bit virtual address, an access kind, a privilege flag and a debug flag. It settles the translation locally whenever it can. In direct-address mode it passes the address straight through. Otherwise it looks for a hit in a bank of privilege-qualified direct-map windows. An address that misses every window and is not sign-extended from the top virtual bit is refused as a bad address. Only canonical addresses that miss every window go out on a lookup port toward the TLB. The block returns the TLB's reply unchanged. The TLB contents and any page-table walk sit behind that port.

Every data path uses a valid/ready handshake. A request is accepted only when `req_ready` is high, and that happens only while the block is idle. The block then holds `req_ready` low until the consumer takes the result. Both the result and the outgoing lookup keep their payload steady while their ready stays low. The mode inputs (`cfg_*`, `win_cfg`) are sampled in the cycle the request is accepted.

Window `i` occupies bits `[9*i+8 : 9*i]` of `win_cfg`, laid out as follows:
- bit 0 enables the window for kernel-level requests.
- bit 1 enables the window for user-level requests.
- bits 5:2 hold the virtual segment.
- bits 8:6 hold the physical segment, which is used only in 32-bit mode.

Status code 0 means translated and code 1 means bad address. Any other code is whatever the TLB reported.

Top module: `addr_xlat_front`

## Requirements
- R1: When `cfg_direct`=1 and `cfg_paging`=0, the result appears one cycle after acceptance with status 0, permission 3'b111 ({exec, write, read}) and `res_paddr` = `req_vaddr[PA_W-1:0]`, and no lookup is issued. Any other combination of these two bits goes through window matching.
- R2: Window `i` matches only if its enable bit for the request's privilege is set (bit 1 when `req_user`=1, bit 0 otherwise) and its segment equals the address segment. In 64-bit mode the address segment is `req_vaddr[63:60]`, compared with bits 5:2. In 32-bit mode it is `req_vaddr[31:29]`, compared with bits 4:2 only.
- R3: When several windows match, the one with the lowest index decides the result.
- R4: A window hit in 64-bit mode yields status 0, permission 3'b111 and `res_paddr` = `req_vaddr` truncated to VA_W bits, one cycle after acceptance.
- R5: A window hit in 32-bit mode yields `res_paddr` = {window bits 8:6, `req_vaddr[28:0]`}, zero-extended, with status 0 and permission 3'b111.
- R6: If no window matches and `req_vaddr[63:VA_W-1]` is neither all zeros nor all ones, the result is status 1, `res_paddr` 0 and permission 0. No lookup is issued.
- R7: A canonical address with no window hit raises a lookup carrying the request's address, access kind, privilege and debug flag. The status, address and permission of the reply are then presented unchanged as the result.
- R8: `req_ready` is high only while nothing is in flight. `res_valid`, `res_paddr`, `res_perm` and `res_status` hold steady until `res_ready` is seen.
- R9: `tlb_req_valid` and its payload hold until `tlb_req_ready`. `tlb_rsp_ready` is high only after the lookup has been taken and before its reply arrives.
- R10: Coming out of reset, `req_ready` is 1, and `res_valid` and `tlb_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_is64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| cfg_direct | input | 1 | Direct-address mode bit |
| cfg_paging | input | 1 | Paging-enable bit |
| win_cfg | input | 9*NUM_WIN | Packed window settings |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| req_user | input | 1 | 1 = user level, 0 = kernel level |
| req_debug | input | 1 | Debug request; lookup side may walk tables |
| tlb_req_valid | output | 1 | Lookup valid |
| tlb_req_ready | input | 1 | Lookup taken |
| tlb_req_vaddr | output | 64 | Lookup address |
| tlb_req_acc | output | 2 | Lookup access kind |
| tlb_req_user | output | 1 | Lookup privilege |
| tlb_req_debug | output | 1 | Lookup debug flag |
| tlb_rsp_valid | input | 1 | Reply valid |
| tlb_rsp_ready | output | 1 | Reply accepted |
| tlb_rsp_status | input | 3 | Reply status |
| tlb_rsp_paddr | input | PA_W | Reply physical address |
| tlb_rsp_perm | input | 3 | Reply permission {x,w,r} |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_paddr | output | PA_W | Physical address |
| res_perm | output | 3 | Permission {x,w,r} |
| res_status | output | 3 | Status code |

## Verification
The bound assertions check the following on every cycle:
- only one request is ever in flight;
- results and lookups hold steady under back-pressure;
- the reply is ready only while the block waits for it;
- direct-mode results and forwarded TLB replies appear one cycle later with the right payload.

Window privilege qualification, lowest-index priority, segment replacement in 32-bit mode, and the choice between canonical lookup and bad-address refusal depend on programmed window contents. Only the bench's scenarios exercise these.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
  // Per-window field layout inside win_cfg
  localparam int WIN_FIELD_W = 9;
  localparam int WF_EN_K     = 0;
  localparam int WF_EN_U     = 1;
  localparam int WF_VSEG_LO  = 2;
  localparam int WF_PSEG_LO  = 6;

  // Segment geometry
  localparam int SEG64_W = 4;
  localparam int SEG32_W = 3;
  localparam int OFF32_W = 29;

  localparam int STAT_W = 3;
  localparam int PERM_W = 3;

  localparam logic [STAT_W-1:0] XS_OK      = 3'd0;
  localparam logic [STAT_W-1:0] XS_BADADDR = 3'd1;
  localparam logic [PERM_W-1:0] PERM_RWX   = 3'b111;
  localparam logic [PERM_W-1:0] PERM_NONE  = 3'b000;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TREQ  = 2'd1,
    S_TWAIT = 2'd2,
    S_RES   = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/addr_xlat_win.sv
module addr_xlat_win
  import addr_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48
) (
  input  logic [63:0]                  vaddr,
  input  logic                         is64,
  input  logic                         user,
  input  logic [NUM_WIN*WIN_FIELD_W-1:0] win_cfg,
  output logic                         hit,
  output logic [PA_W-1:0]              paddr
);
  localparam logic [63:0] VA_MASK = (64'd1 << VA_W) - 64'd1;

  logic [NUM_WIN-1:0] hit_v;
  logic [PA_W-1:0]    pa_v [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [WIN_FIELD_W-1:0] fld;
    logic                   en;
    logic                   seg_eq;
    logic [63:0]            pa_full;

    assign fld    = win_cfg[g*WIN_FIELD_W +: WIN_FIELD_W];
    assign en     = user ? fld[WF_EN_U] : fld[WF_EN_K];
    assign seg_eq = is64 ? (vaddr[63 -: SEG64_W] == fld[WF_VSEG_LO +: SEG64_W])
                         : (vaddr[31 -: SEG32_W] == fld[WF_VSEG_LO +: SEG32_W]);
    assign hit_v[g] = en & seg_eq;
    assign pa_full  = is64 ? (vaddr & VA_MASK)
                           : {32'd0, fld[WF_PSEG_LO +: SEG32_W], vaddr[OFF32_W-1:0]};
    assign pa_v[g]  = pa_full[PA_W-1:0];
  end

  // Lowest index wins: scan downward so the last write is the lowest hit.
  always_comb begin
    hit   = |hit_v;
    paddr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_v[i]) paddr = pa_v[i];
    end
  end
endmodule

// File: rtl/addr_xlat_canon.sv
module addr_xlat_canon #(
  parameter int VA_W = 48
) (
  input  logic [63:0] vaddr,
  output logic        canon
);
  localparam int HI_W = 64 - VA_W + 1;

  logic [HI_W-1:0] hi;
  assign hi    = vaddr[63:VA_W-1];
  assign canon = (hi == '0) || (hi == '1);
endmodule

// File: rtl/addr_xlat_ctrl.sv
module addr_xlat_ctrl
  import addr_xlat_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic              req_debug,
  input  logic              loc_take,
  input  logic [PA_W-1:0]   loc_paddr,
  input  logic [PERM_W-1:0] loc_perm,
  input  logic [STAT_W-1:0] loc_status,
  output logic              tlb_req_valid,
  input  logic              tlb_req_ready,
  output logic [63:0]       tlb_req_vaddr,
  output logic [1:0]        tlb_req_acc,
  output logic              tlb_req_user,
  output logic              tlb_req_debug,
  input  logic              tlb_rsp_valid,
  output logic              tlb_rsp_ready,
  input  logic [STAT_W-1:0] tlb_rsp_status,
  input  logic [PA_W-1:0]   tlb_rsp_paddr,
  input  logic [PERM_W-1:0] tlb_rsp_perm,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm,
  output logic [STAT_W-1:0] res_status
);
  ctl_state_e st_q;

  assign req_ready     = (st_q == S_IDLE);
  assign tlb_req_valid = (st_q == S_TREQ);
  assign tlb_rsp_ready = (st_q == S_TWAIT);
  assign res_valid     = (st_q == S_RES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      tlb_req_vaddr <= '0;
      tlb_req_acc   <= '0;
      tlb_req_user  <= 1'b0;
      tlb_req_debug <= 1'b0;
      res_paddr     <= '0;
      res_perm      <= PERM_NONE;
      res_status    <= XS_OK;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            tlb_req_vaddr <= req_vaddr;
            tlb_req_acc   <= req_acc;
            tlb_req_user  <= req_user;
            tlb_req_debug <= req_debug;
            if (loc_take) begin
              res_paddr  <= loc_paddr;
              res_perm   <= loc_perm;
              res_status <= loc_status;
              st_q       <= S_RES;
            end else begin
              st_q <= S_TREQ;
            end
          end
        end
        S_TREQ: begin
          if (tlb_req_ready) st_q <= S_TWAIT;
        end
        S_TWAIT: begin
          if (tlb_rsp_valid) begin
            res_paddr  <= tlb_rsp_paddr;
            res_perm   <= tlb_rsp_perm;
            res_status <= tlb_rsp_status;
            st_q       <= S_RES;
          end
        end
        S_RES: begin
          if (res_ready) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlat_front.sv
module addr_xlat_front
  import addr_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_is64,
  input  logic                           cfg_direct,
  input  logic                           cfg_paging,
  input  logic [NUM_WIN*WIN_FIELD_W-1:0] win_cfg,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [63:0]                    req_vaddr,
  input  logic [1:0]                     req_acc,
  input  logic                           req_user,
  input  logic                           req_debug,
  output logic                           tlb_req_valid,
  input  logic                           tlb_req_ready,
  output logic [63:0]                    tlb_req_vaddr,
  output logic [1:0]                     tlb_req_acc,
  output logic                           tlb_req_user,
  output logic                           tlb_req_debug,
  input  logic                           tlb_rsp_valid,
  output logic                           tlb_rsp_ready,
  input  logic [STAT_W-1:0]              tlb_rsp_status,
  input  logic [PA_W-1:0]                tlb_rsp_paddr,
  input  logic [PERM_W-1:0]              tlb_rsp_perm,
  output logic                           res_valid,
  input  logic                           res_ready,
  output logic [PA_W-1:0]                res_paddr,
  output logic [PERM_W-1:0]              res_perm,
  output logic [STAT_W-1:0]              res_status
);
  logic              win_hit;
  logic [PA_W-1:0]   win_paddr;
  logic              canon;
  logic              direct_mode;
  logic              loc_take;
  logic [PA_W-1:0]   loc_paddr;
  logic [PERM_W-1:0] loc_perm;
  logic [STAT_W-1:0] loc_status;

  addr_xlat_win #(.NUM_WIN(NUM_WIN), .VA_W(VA_W), .PA_W(PA_W)) win_i (
    .vaddr   (req_vaddr),
    .is64    (cfg_is64),
    .user    (req_user),
    .win_cfg (win_cfg),
    .hit     (win_hit),
    .paddr   (win_paddr)
  );

  addr_xlat_canon #(.VA_W(VA_W)) canon_i (
    .vaddr (req_vaddr),
    .canon (canon)
  );

  assign direct_mode = cfg_direct & ~cfg_paging;

  always_comb begin
    loc_take   = direct_mode | win_hit | ~canon;
    loc_paddr  = '0;
    loc_perm   = PERM_NONE;
    loc_status = XS_BADADDR;
    if (direct_mode) begin
      loc_paddr  = req_vaddr[PA_W-1:0];
      loc_perm   = PERM_RWX;
      loc_status = XS_OK;
    end else if (win_hit) begin
      loc_paddr  = win_paddr;
      loc_perm   = PERM_RWX;
      loc_status = XS_OK;
    end
  end

  addr_xlat_ctrl #(.PA_W(PA_W)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .req_acc        (req_acc),
    .req_user       (req_user),
    .req_debug      (req_debug),
    .loc_take       (loc_take),
    .loc_paddr      (loc_paddr),
    .loc_perm       (loc_perm),
    .loc_status     (loc_status),
    .tlb_req_valid  (tlb_req_valid),
    .tlb_req_ready  (tlb_req_ready),
    .tlb_req_vaddr  (tlb_req_vaddr),
    .tlb_req_acc    (tlb_req_acc),
    .tlb_req_user   (tlb_req_user),
    .tlb_req_debug  (tlb_req_debug),
    .tlb_rsp_valid  (tlb_rsp_valid),
    .tlb_rsp_ready  (tlb_rsp_ready),
    .tlb_rsp_status (tlb_rsp_status),
    .tlb_rsp_paddr  (tlb_rsp_paddr),
    .tlb_rsp_perm   (tlb_rsp_perm),
    .res_valid      (res_valid),
    .res_ready      (res_ready),
    .res_paddr      (res_paddr),
    .res_perm       (res_perm),
    .res_status     (res_status)
  );
endmodule

module addr_xlat_front_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_direct,
  input logic            cfg_paging,
  input logic            req_valid,
  input logic            req_ready,
  input logic [63:0]     req_vaddr,
  input logic            tlb_req_valid,
  input logic            tlb_req_ready,
  input logic [63:0]     tlb_req_vaddr,
  input logic            tlb_rsp_valid,
  input logic            tlb_rsp_ready,
  input logic [2:0]      tlb_rsp_status,
  input logic [PA_W-1:0] tlb_rsp_paddr,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic [2:0]      res_perm,
  input logic [2:0]      res_status
);
  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid && !tlb_req_valid && !tlb_rsp_ready));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr)
                                   && $stable(res_perm) && $stable(res_status)));

  assert_lookup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && !tlb_req_ready) |=> (tlb_req_valid && $stable(tlb_req_vaddr)));

  assert_rsp_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_rsp_ready |-> (!tlb_req_valid && !res_valid));

  assert_direct_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_direct && !cfg_paging) |=>
      (res_valid && res_status == 3'd0 && res_perm == 3'b111
       && res_paddr == $past(req_vaddr[PA_W-1:0])));

  assert_reply_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_rsp_valid && tlb_rsp_ready) |=>
      (res_valid && res_status == $past(tlb_rsp_status)
       && res_paddr == $past(tlb_rsp_paddr)));
endmodule

bind addr_xlat_front addr_xlat_front_chk #(.PA_W(PA_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_direct     (cfg_direct),
  .cfg_paging     (cfg_paging),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .tlb_req_valid  (tlb_req_valid),
  .tlb_req_ready  (tlb_req_ready),
  .tlb_req_vaddr  (tlb_req_vaddr),
  .tlb_rsp_valid  (tlb_rsp_valid),
  .tlb_rsp_ready  (tlb_rsp_ready),
  .tlb_rsp_status (tlb_rsp_status),
  .tlb_rsp_paddr  (tlb_rsp_paddr),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_paddr      (res_paddr),
  .res_perm       (res_perm),
  .res_status     (res_status)
);

// File: tb/addr_xlat_front_tb_top.sv
`timescale 1ns/1ps
module addr_xlat_front_tb_top;
  localparam int NW = 4;
  localparam int PA = 48;

  typedef struct packed {
    logic        is64;
    logic        direct;
    logic        paging;
    logic        user;
    logic        debug;
    logic [63:0] va;
    logic [35:0] win;
    logic [2:0]  st;
    logic [47:0] pa;
    logic [2:0]  perm;
    logic        tlb;
    logic [3:0]  rq;
  } vec_t;

  // windows for 64-bit cases: 0 seg9 kernel, 1 seg9 user, 2/3 seg8 both
  localparam logic [35:0] WA = {{3'd0, 4'h8, 2'b11}, {3'd0, 4'h8, 2'b11},
                                {3'd0, 4'h9, 2'b10}, {3'd0, 4'h9, 2'b01}};
  // windows for 32-bit cases: 0 seg5 user pseg1, 1 seg5 both pseg2,
  // 2 segC kernel pseg6, 3 seg4 kernel pseg7
  localparam logic [35:0] WB = {{3'd7, 4'h4, 2'b01}, {3'd6, 4'hC, 2'b01},
                                {3'd2, 4'h5, 2'b11}, {3'd1, 4'h5, 2'b10}};

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 64'hFFFF_1234_5678_9ABC, WA, 3'd0, 48'h1234_5678_9ABC, 3'b111, 1'b0, 4'd1}, // R1
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 64'h9000_0000_0000_1000, WA, 3'd0, 48'h0000_0000_1000, 3'b111, 1'b0, 4'd4}, // R4
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 64'h9000_0012_3456_7890, WA, 3'd0, 48'h0012_3456_7890, 3'b111, 1'b0, 4'd2}, // R2
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 64'h8000_ABCD_0000_0044, WA, 3'd0, 48'hABCD_0000_0044, 3'b111, 1'b0, 4'd4}, // R4
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 64'h0000_0000_A123_4567, WB, 3'd0, 48'h0000_2123_4567, 3'b111, 1'b0, 4'd5}, // R5
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 64'h0000_0000_A123_4567, WB, 3'd0, 48'h0000_4123_4567, 3'b111, 1'b0, 4'd2}, // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 64'h0000_0000_8000_0010, WB, 3'd0, 48'h0000_C000_0010, 3'b111, 1'b0, 4'd3}, // R3
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 64'h0001_0000_0000_0000, WA, 3'd1, 48'h0,              3'b000, 1'b0, 4'd6}, // R6
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 64'hFFFF_8000_0000_1000, WA, 3'd2, 48'h0,              3'b000, 1'b1, 4'd7}, // R7
    '{1'b1,1'b0,1'b1,1'b0,1'b1, 64'h0000_7FFF_0000_2000, WA, 3'd0, 48'h7F0F_0000_2000, 3'b101, 1'b1, 4'd7}, // R7
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 64'h0000_0000_0000_0100, WA, 3'd2, 48'h0,              3'b000, 1'b1, 4'd1}, // R1
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 64'h0000_0000_2000_0000, WB, 3'd2, 48'h0,              3'b000, 1'b1, 4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 64'h1234_0000_0000_0000, WB, 3'd1, 48'h0,              3'b000, 1'b0, 4'd6}, // R6
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 64'h0000_0000_8000_0010, WB, 3'd2, 48'h0,              3'b000, 1'b1, 4'd2}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_is64 = 1'b1, cfg_direct = 1'b0, cfg_paging = 1'b1;
  logic [35:0] win_cfg = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = 2'd0;
  logic        req_user = 1'b0, req_debug = 1'b0;
  logic        tlb_req_valid;
  logic        tlb_req_ready = 1'b1;
  logic [63:0] tlb_req_vaddr;
  logic [1:0]  tlb_req_acc;
  logic        tlb_req_user, tlb_req_debug;
  logic        tlb_rsp_valid = 1'b0;
  logic        tlb_rsp_ready;
  logic [2:0]  tlb_rsp_status = '0;
  logic [PA-1:0] tlb_rsp_paddr = '0;
  logic [2:0]  tlb_rsp_perm = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [PA-1:0] res_paddr;
  logic [2:0]  res_perm, res_status;

  int n_chk = 0, n_bad = 0;
  int tlb_stall = 0;
  logic tlb_seen = 1'b0;
  logic [63:0] cap_va;
  logic [1:0]  cap_acc;

  always #2.5 clk = ~clk;

  addr_xlat_front #(.NUM_WIN(NW), .VA_W(48), .PA_W(PA)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_is64(cfg_is64), .cfg_direct(cfg_direct),
    .cfg_paging(cfg_paging), .win_cfg(win_cfg), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .req_user(req_user), .req_debug(req_debug), .tlb_req_valid(tlb_req_valid),
    .tlb_req_ready(tlb_req_ready), .tlb_req_vaddr(tlb_req_vaddr),
    .tlb_req_acc(tlb_req_acc), .tlb_req_user(tlb_req_user),
    .tlb_req_debug(tlb_req_debug), .tlb_rsp_valid(tlb_rsp_valid),
    .tlb_rsp_ready(tlb_rsp_ready), .tlb_rsp_status(tlb_rsp_status),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_perm(tlb_rsp_perm),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_perm(res_perm), .res_status(res_status)
  );

  task automatic chk(input logic ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Lookup-side model: debug requests translate, others miss with code 2.
  initial begin
    forever begin
      @(negedge clk);
      if (tlb_req_valid) begin
        cap_va  = tlb_req_vaddr;
        cap_acc = tlb_req_acc;
        for (int k = 0; k < tlb_stall; k++) begin
          tlb_req_ready = 1'b0;
          @(negedge clk);
          chk(tlb_req_valid && tlb_req_vaddr == cap_va && !res_valid, "R9 stall",
              {63'd0, tlb_req_valid}, 64'd1);
        end
        tlb_stall = 0;
        tlb_req_ready = 1'b1;
        tlb_seen = 1'b1;
        @(negedge clk);
        tlb_rsp_status = tlb_req_debug ? 3'd0 : 3'd2;
        tlb_rsp_paddr  = tlb_req_debug ? (cap_va[47:0] ^ 48'h00F0_0000_0000) : '0;
        tlb_rsp_perm   = tlb_req_debug ? 3'b101 : 3'b000;
        tlb_rsp_valid  = 1'b1;
        chk(tlb_rsp_ready, "R9 rsp ready", {63'd0, tlb_rsp_ready}, 64'd1);
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int hold);
    @(negedge clk);
    cfg_is64 = v.is64; cfg_direct = v.direct; cfg_paging = v.paging;
    win_cfg = v.win; req_vaddr = v.va; req_user = v.user; req_debug = v.debug;
    req_acc = 2'd1; tlb_seen = 1'b0;
    chk(req_ready, "R8 idle ready", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!v.tlb) chk(res_valid, $sformatf("R%0d latency", v.rq), {63'd0, res_valid}, 64'd1);
    while (!res_valid) @(negedge clk);
    chk(res_status == v.st, $sformatf("R%0d status", v.rq), {61'd0, res_status}, {61'd0, v.st});
    chk(res_paddr == v.pa, $sformatf("R%0d paddr", v.rq), {16'd0, res_paddr}, {16'd0, v.pa});
    chk(res_perm == v.perm, $sformatf("R%0d perm", v.rq), {61'd0, res_perm}, {61'd0, v.perm});
    chk(tlb_seen == v.tlb, $sformatf("R%0d lookup issued", v.rq), {63'd0, tlb_seen}, {63'd0, v.tlb});
    if (v.tlb)
      chk(cap_va == v.va && cap_acc == 2'd1, "R7 lookup payload", cap_va, v.va);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(res_valid && res_paddr == v.pa && !req_ready, "R8 result hold",
          {16'd0, res_paddr}, {16'd0, v.pa});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R8 release", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog actual=%0d expected<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle state after reset
    chk(req_ready, "R10 req_ready", {63'd0, req_ready}, 64'd1);
    chk(!res_valid, "R10 res_valid", {63'd0, res_valid}, 64'd0);
    chk(!tlb_req_valid, "R10 tlb_req_valid", {63'd0, tlb_req_valid}, 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);

    // R8: hold a local result under back-pressure
    run_vec(VECS[3], 3);
    // R9: stall the lookup port, then the reply is forwarded (R7)
    tlb_stall = 3;
    run_vec(VECS[9], 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule